// File: doc/BRIEF.md
# Minute Pulse Time Base

This block turns a slow square-wave tick, typically a 60 Hz mains-derived signal already brought into logic levels, into one output pulse per minute. The tick is brought into the system clock domain by a synchronizer. Each falling edge of the tick advances a 12-stage binary up-counter.

The block does not compare the whole count against a constant. It watches four counter bits whose weights add up to 3600. When all four are high, the block emits a single-cycle pulse and clears the counter back to zero. With a 60 Hz tick this gives a 1/3600 division, which is one pulse every 60 seconds.

The full count is exposed so that a consumer can also read the fraction of the minute that has elapsed.

Top module: `minute_base`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count and the pulse output are both 0 after that edge, and tick activity during reset changes neither.
- R2: Each falling edge of `tick_i` (1 then 0 in consecutive samples) raises the count by exactly one. The new value appears on the second rising clock edge after the edge that first samples `tick_i` low.
- R3: Without a falling edge on `tick_i` the count holds its value, both while the tick level is steady and across a rising edge.
- R4: The terminal state is count bits 4, 9, 10 and 11 all high (bit 0 is the least significant bit), which is the value 3600. On the clock edge after that state is reached, the count becomes 0 and `pulse_o` is high for exactly that one cycle.
- R5: The count never exceeds 3600, and the value 3600 is held for exactly one clock cycle.
- R6: Exactly 3600 falling tick edges separate consecutive pulses. The same holds from the release of reset to the first pulse.
- R7: Reset wins over the decode clear: a reset applied in the cycle the count shows 3600 produces no pulse and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, sampled on the rising clock edge |
| tick_i | input | 1 | Slow tick, asynchronous to `clk` |
| count_o | output | 12 | Current count value |
| pulse_o | output | 1 | One-cycle pulse on terminal count |

## Verification
A falling tick edge reaches `count_o` on the second rising edge after the one that first samples the low level. The terminal pulse and the clear follow one rising edge after the count shows 3600. Reset acts on the next rising edge.

The bench holds a reference model that steps on every rising edge and mirrors these delays. It compares the model with the outputs at the falling edge of every cycle, so each result is sampled in the cycle it is due and never in the cycle it changes. Tick falls are counted where they are driven and are checked against each pulse, independently of the counter.

// File: rtl/minute_base_pkg.sv
package minute_base_pkg;
  localparam int unsigned CNT_W = 12;
  // bits 11,10,9,4 -> 2048+1024+512+16 = 3600
  localparam logic [CNT_W-1:0] TAP_MASK = 12'hE10;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic int unsigned tap_value(input logic [CNT_W-1:0] mask);
    return int'(mask);
  endfunction
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= tick_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign fall_o = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic [W-1:0] value_i,
  output logic         hit_o
);
  assign hit_o = &(value_i | ~MASK);
endmodule

// File: rtl/clear_counter.sv
module clear_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         clear_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign value_o = cnt_q;
endmodule

// File: rtl/minute_base.sv
module minute_base
  import minute_base_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pulse_o
);
  logic fall;
  logic hit;
  logic pulse_q;

  tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .fall_o (fall)
  );

  clear_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .step_i  (fall),
    .clear_i (hit),
    .value_o (count_o)
  );

  tap_decode #(.W(CNT_W), .MASK(TAP_MASK)) u_dec (
    .value_i (count_o),
    .hit_o   (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= hit;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/minute_base_chk.sv
module minute_base_chk #(
  parameter int unsigned W = 12,
  parameter int unsigned TERM = 3600
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count_o,
  input logic         pulse_o
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (count_o == '0) && !pulse_o);

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (!pulse_o && !$stable(count_o)) |-> (count_o == $past(count_o) + 1'b1));

  p_term_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (count_o == W'(TERM)) |=> (count_o == '0) && pulse_o);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    count_o <= W'(TERM));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (count_o == '0) && ($past(count_o) == W'(TERM)) && !$past(rst));
endmodule

bind minute_base minute_base_chk #(
  .W    (minute_base_pkg::CNT_W),
  .TERM (minute_base_pkg::tap_value(minute_base_pkg::TAP_MASK))
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .count_o (count_o),
  .pulse_o (pulse_o)
);

// File: tb/sim_minute_base.sv
module sim_minute_base;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic [11:0] count_o;
  logic        pulse_o;

  int checks = 0;
  int errors = 0;
  int falls_since = 0;
  int pulses = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 0;
  bit m_pulse = 0;
  bit h0 = 0, h1 = 0, h2 = 0;

  always #2.5 clk = ~clk;

  minute_base u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .count_o(count_o), .pulse_o(pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model: synchronized history, edge a cycle later, clear one cycle after 3600
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pulse = 0; h0 = 0; h1 = 0; h2 = 0;
    end else begin
      bit edge_seen;
      edge_seen = h2 && !h1;
      m_pulse = (m_cnt == 3600);
      if (m_cnt == 3600) m_cnt = 0;
      else if (edge_seen) m_cnt = m_cnt + 1;
      h2 = h1; h1 = h0; h0 = tick_i;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(int'(count_o) == m_cnt, "R2 count vs model", int'(count_o), m_cnt);
      check(pulse_o == m_pulse, "R4 pulse vs model", pulse_o, m_pulse);
      check(count_o <= 12'd3600, "R5 count bound", int'(count_o), 3600);
      if (pulse_o) begin
        pulses++;
        check(falls_since == 3600, "R6 falls between pulses", falls_since, 3600);
        falls_since = 0;
      end
    end
  end

  task automatic one_tick();
    tick_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_i = 1'b0;
    if (!rst) falls_since++;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) one_tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int held;
    int p0;
    repeat (5) @(negedge clk);
    check(count_o == 0, "R1 reset count", int'(count_o), 0);
    check(pulse_o == 0, "R1 reset pulse", pulse_o, 0);
    rst = 1'b0;
    falls_since = 0;

    ticks(5);
    check(count_o == 5, "R2 five falls", int'(count_o), 5);

    held = int'(count_o);
    tick_i = 1'b1;
    repeat (30) @(negedge clk);
    check(int'(count_o) == held, "R3 rise and high level", int'(count_o), held);
    tick_i = 1'b1;
    repeat (30) @(negedge clk);
    check(int'(count_o) == held, "R3 steady high", int'(count_o), held);
    tick_i = 1'b0;
    falls_since++;
    repeat (10) @(negedge clk);
    check(int'(count_o) == held + 1, "R2 single fall", int'(count_o), held + 1);
    repeat (30) @(negedge clk);
    check(int'(count_o) == held + 1, "R3 steady low", int'(count_o), held + 1);

    ticks(7200 - 6);
    repeat (10) @(negedge clk);
    check(pulses == 2, "R6 two minutes", pulses, 2);
    check(count_o == 0, "R4 cleared after terminal", int'(count_o), 0);

    // R7: reset in the terminal cycle
    ticks(3599);
    check(count_o == 3599, "R7 setup", int'(count_o), 3599);
    p0 = pulses;
    tick_i = 1'b1;
    repeat (4) @(negedge clk);
    tick_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (count_o == 12'd3600) begin
        rst = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(rst == 1'b1, "R7 terminal reached", rst, 1);
    @(negedge clk);
    check(pulse_o == 0, "R7 no pulse under reset", pulse_o, 0);
    check(count_o == 0, "R7 count under reset", int'(count_o), 0);
    ticks(10);
    check(count_o == 0, "R1 ticks ignored in reset", int'(count_o), 0);
    check(pulses == p0, "R7 pulse count", pulses, p0);
    tick_i = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    falls_since = 0;
    repeat (3) @(negedge clk);
    tick_i = 1'b0;
    falls_since++;
    repeat (4) @(negedge clk);
    ticks(3599);
    repeat (10) @(negedge clk);
    check(pulses == p0 + 1, "R6 minute after reset", pulses, p0 + 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule